// File: doc/BRIEF.md
# Logical Device Address Decoder

This block sits between the configuration register file of a multi-function I/O controller and the host I/O bus. It turns the stored configuration into address windows and, for each host I/O access, raises a chip select toward the one function that owns the address. Six functions have programmable windows: a floppy controller, two UARTs, a parallel port, a single-byte auxiliary register and a two-wire serial bus interface. A seventh, a small general-purpose I/O window, sits at one of four fixed low addresses picked by a two-bit selector.

A programmable window is live only when its function is switched on in the global enable byte and its own activate byte is nonzero, and its 16-bit base lies inside a legal range for its span. A base outside that range turns the window off; it never wraps. When windows overlap, a fixed priority picks a single winner. An access that lands in no live window is flagged. The block also sanitises the parallel port interrupt number, mapping any value above 15 to the "no interrupt" code. All decoding is combinational; results follow the inputs with no clock.

Top module: `lda_decoder`

## Requirements
- R1: A window for the floppy controller, first UART, second UART, parallel port or two-wire bus is live only when its global enable bit is set in `glb_enable_i`: bit 0 floppy, bit 4 first UART, bit 5 second UART, bit 3 parallel port, bit 6 two-wire bus. Other bits have no effect.
- R2: A programmable window is live only when its 8-bit activate byte in `dev_act_i` is nonzero. Device slot k occupies bits [8k+7:8k] of `dev_act_i`, `dev_base_hi_i` and `dev_base_lo_i`; slots are 0 floppy, 1 first UART, 2 second UART, 3 parallel port, 4 auxiliary, 5 two-wire bus.
- R3: A window's base is {high byte, low byte} and it covers base up to base+span-1, with span 8 for floppy and both UARTs, 4 for parallel port and two-wire bus, 1 for the auxiliary register; all 16 address bits take part in the compare.
- R4: A window whose base is below 0x0100 or above its limit (0x0FF8 for span 8, 0x0FFC for span 4, 0x0FFF for span 1) decodes nothing.
- R5: The auxiliary window depends on no global enable bit, only on its activate byte and base.
- R6: The general-purpose I/O window is live when bit 7 of `gpio_ctrl_i` is set; bits [1:0] select base 0x00E0, 0x00E2, 0x00E4 or 0x00EA for values 0 to 3; it spans 2 bytes; the other bits have no effect.
- R7: `sel_o` bit 0 floppy, 1 first UART, 2 second UART, 3 parallel port, 4 auxiliary, 5 two-wire bus, 6 general-purpose I/O; at most one bit is set, and on overlap the lowest-numbered hitting window wins.
- R8: With `io_strobe_i` low, `sel_o` is zero and `miss_o` is low.
- R9: With `io_strobe_i` high, `miss_o` is high exactly when no live window contains the address.
- R10: `lpt_irq_o` equals `lpt_irq_i` for values 0 to 15 and 0xFF for any value above 15.
- R11: All outputs are combinational functions of the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr_i | input | 16 | Host I/O address |
| io_strobe_i | input | 1 | Host I/O access in progress |
| glb_enable_i | input | 8 | Global function enable byte |
| gpio_ctrl_i | input | 8 | GPIO window control: bit 7 enable, bits [1:0] base select |
| dev_act_i | input | 48 | Activate bytes, one per device slot |
| dev_base_hi_i | input | 48 | Base high bytes, one per device slot |
| dev_base_lo_i | input | 48 | Base low bytes, one per device slot |
| lpt_irq_i | input | 8 | Stored parallel port interrupt number |
| sel_o | output | 7 | One-hot-or-zero chip selects |
| miss_o | output | 1 | Strobed access hit no live window |
| lpt_irq_o | output | 8 | Sanitised parallel port interrupt number |

## Verification
Every result of this block is due in the same cycle as its stimulus, since selects, miss flag and interrupt code are pure combinational functions of the inputs. The bench changes inputs on the falling clock edge and samples a quarter period later, well before the next rising edge, so each check sees the settled decode of exactly one stimulus. Address sweeps cover 0x0000 to 0x1FFF under several configurations, which crosses every window edge, every legal-range boundary and the upper address bits.

// File: rtl/lda_pkg.sv
package lda_pkg;
  localparam int ADDR_W   = 16;
  localparam int CFG_W    = 8;
  localparam int NUM_DEV  = 6;
  localparam int NUM_WIN  = NUM_DEV + 1;
  localparam int GPIO_IDX = NUM_DEV;
  localparam int GPIO_SPAN = 2;
  localparam int BASE_MIN = 'h0100;
  localparam int BASE_TOP = 'h1000;
  localparam int IRQ_MAX  = 15;

  // device slot order doubles as select priority
  localparam int DEV_FDC  = 0;
  localparam int DEV_UA0  = 1;
  localparam int DEV_UA1  = 2;
  localparam int DEV_LPT  = 3;
  localparam int DEV_AUX  = 4;
  localparam int DEV_BUS  = 5;

  function automatic int win_span(input int idx);
    case (idx)
      DEV_FDC, DEV_UA0, DEV_UA1: return 8;
      DEV_LPT, DEV_BUS:          return 4;
      default:                   return 1;
    endcase
  endfunction

  function automatic int win_limit(input int idx);
    return BASE_TOP - win_span(idx);
  endfunction

  // -1 means no global gate
  function automatic int glb_bit(input int idx);
    case (idx)
      DEV_FDC: return 0;
      DEV_UA0: return 4;
      DEV_UA1: return 5;
      DEV_LPT: return 3;
      DEV_BUS: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] gpio_base(input logic [1:0] pick);
    case (pick)
      2'd0:    return ADDR_W'('h00E0);
      2'd1:    return ADDR_W'('h00E2);
      2'd2:    return ADDR_W'('h00E4);
      default: return ADDR_W'('h00EA);
    endcase
  endfunction
endpackage

// File: rtl/lda_window.sv
module lda_window #(
  parameter int ADDR_W   = 16,
  parameter int CFG_W    = 8,
  parameter int SPAN     = 8,
  parameter int BASE_MIN = 'h0100,
  parameter int BASE_MAX = 'h0FF8,
  parameter bit USE_GLB  = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              glb_en_i,
  input  logic [CFG_W-1:0]  act_i,
  input  logic [CFG_W-1:0]  base_hi_i,
  input  logic [CFG_W-1:0]  base_lo_i,
  output logic              live_o,
  output logic              hit_o
);
  localparam int BASE_W = 2 * CFG_W;

  logic [BASE_W-1:0] base;
  logic [ADDR_W-1:0] offset;
  logic              gate_ok, range_ok;

  assign base     = {base_hi_i, base_lo_i};
  assign gate_ok  = USE_GLB ? glb_en_i : 1'b1;
  assign range_ok = (32'(base) >= BASE_MIN) && (32'(base) <= BASE_MAX);
  assign live_o   = gate_ok && (|act_i) && range_ok;
  assign offset   = addr_i - ADDR_W'(base);
  assign hit_o    = live_o && (addr_i >= ADDR_W'(base)) && (32'(offset) < SPAN);

  always_comb begin
    // R4: a hit implies the base lay inside the legal range
    assert_hit_in_range_R4: assert (!hit_o || (32'(base) <= BASE_MAX && 32'(base) >= BASE_MIN));
  end
endmodule

// File: rtl/lda_gpio_window.sv
module lda_gpio_window
  import lda_pkg::*;
#(
  parameter int ADDR_W = lda_pkg::ADDR_W,
  parameter int CFG_W  = lda_pkg::CFG_W,
  parameter int SPAN   = lda_pkg::GPIO_SPAN
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  ctrl_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  assign base   = gpio_base(ctrl_i[1:0]);
  assign offset = addr_i - base;
  assign hit_o  = ctrl_i[CFG_W-1] && (addr_i >= base) && (32'(offset) < SPAN);

  always_comb begin
    // R6: a hit lies in the low fixed area where every selectable base sits
    assert_gpio_low_R6: assert (!hit_o || addr_i < ADDR_W'('h00F0));
  end
endmodule

// File: rtl/lda_prio.sv
module lda_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    // R7: a grant only goes to a requester, never more than one
    assert_gnt_onehot_R7: assert ($onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
  end
endmodule

// File: rtl/lda_decoder.sv
module lda_decoder
  import lda_pkg::*;
#(
  parameter int ADDR_W  = lda_pkg::ADDR_W,
  parameter int CFG_W   = lda_pkg::CFG_W,
  parameter int NUM_DEV = lda_pkg::NUM_DEV,
  parameter int IRQ_MAX = lda_pkg::IRQ_MAX
) (
  input  logic [ADDR_W-1:0]        io_addr_i,
  input  logic                     io_strobe_i,
  input  logic [CFG_W-1:0]         glb_enable_i,
  input  logic [CFG_W-1:0]         gpio_ctrl_i,
  input  logic [NUM_DEV*CFG_W-1:0] dev_act_i,
  input  logic [NUM_DEV*CFG_W-1:0] dev_base_hi_i,
  input  logic [NUM_DEV*CFG_W-1:0] dev_base_lo_i,
  input  logic [CFG_W-1:0]         lpt_irq_i,
  output logic [NUM_DEV:0]         sel_o,
  output logic                     miss_o,
  output logic [CFG_W-1:0]         lpt_irq_o
);
  localparam int NWIN = NUM_DEV + 1;

  logic [NWIN-1:0]    win_hit;
  logic [NUM_DEV-1:0] win_live;
  logic [NWIN-1:0]    req;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_win
    localparam int GB = glb_bit(g);
    logic glb_en;
    if (GB >= 0) begin : g_gated
      assign glb_en = glb_enable_i[GB];
    end else begin : g_free
      assign glb_en = 1'b1;
    end
    lda_window #(
      .ADDR_W  (ADDR_W),
      .CFG_W   (CFG_W),
      .SPAN    (win_span(g)),
      .BASE_MIN(BASE_MIN),
      .BASE_MAX(win_limit(g)),
      .USE_GLB (GB >= 0)
    ) u_win (
      .addr_i   (io_addr_i),
      .glb_en_i (glb_en),
      .act_i    (dev_act_i[g*CFG_W +: CFG_W]),
      .base_hi_i(dev_base_hi_i[g*CFG_W +: CFG_W]),
      .base_lo_i(dev_base_lo_i[g*CFG_W +: CFG_W]),
      .live_o   (win_live[g]),
      .hit_o    (win_hit[g])
    );
  end

  lda_gpio_window #(
    .ADDR_W(ADDR_W),
    .CFG_W (CFG_W)
  ) u_gpio (
    .addr_i(io_addr_i),
    .ctrl_i(gpio_ctrl_i),
    .hit_o (win_hit[NWIN-1])
  );

  assign req = win_hit & {NWIN{io_strobe_i}};

  lda_prio #(.N(NWIN)) u_prio (
    .req_i(req),
    .gnt_o(sel_o)
  );

  assign miss_o    = io_strobe_i && (req == '0);
  assign lpt_irq_o = (32'(lpt_irq_i) > IRQ_MAX) ? '1 : lpt_irq_i;

  always_comb begin
    assert_sel_onehot_R7: assert ($onehot0(sel_o));
    // R8: no strobe, no select and no miss
    assert_idle_quiet_R8: assert (io_strobe_i || (sel_o == '0 && !miss_o));
    // R9: a strobed access either selects or misses, never both
    assert_miss_excl_R9: assert (!io_strobe_i || (miss_o != (|sel_o)));
    // R10: sanitised code is a real line or the none code
    assert_irq_code_R10: assert (32'(lpt_irq_o) <= IRQ_MAX || lpt_irq_o == '1);
    // R2: a window that is not live never selects
    assert_dead_quiet_R2: assert ((sel_o[NUM_DEV-1:0] & ~win_live) == '0);
  end
endmodule

// File: tb/tb_lda_decoder.sv
`timescale 1ns/1ps
module tb_lda_decoder;
  localparam int ND = 6;

  logic        clk = 1'b0;
  logic [15:0] addr;
  logic        strobe;
  logic [7:0]  glb, gctl, irq_in;
  logic [47:0] act_v, hi_v, lo_v;
  logic [6:0]  sel;
  logic        miss;
  logic [7:0]  irq_out;

  int errors = 0;
  int checks = 0;

  logic [7:0]  c_act [ND];
  logic [15:0] c_base[ND];

  always #10 clk = ~clk;

  lda_decoder dut (
    .io_addr_i(addr), .io_strobe_i(strobe), .glb_enable_i(glb),
    .gpio_ctrl_i(gctl), .dev_act_i(act_v), .dev_base_hi_i(hi_v),
    .dev_base_lo_i(lo_v), .lpt_irq_i(irq_in), .sel_o(sel),
    .miss_o(miss), .lpt_irq_o(irq_out)
  );

  function automatic int span_of(int k);
    if (k <= 2) return 8;
    if (k == 4) return 1;
    return 4;
  endfunction

  function automatic logic gate_of(int k, logic [7:0] g);
    case (k)
      0: return g[0];
      1: return g[4];
      2: return g[5];
      3: return g[3];
      5: return g[6];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [6:0] model_sel(logic [15:0] a);
    logic [6:0] hits;
    int gb;
    hits = '0;
    for (int k = 0; k < ND; k++) begin
      int b, s;
      b = int'(c_base[k]);
      s = span_of(k);
      if (gate_of(k, glb) && c_act[k] != 0 && b >= 256 && b <= 4096 - s &&
          int'(a) >= b && int'(a) < b + s)
        hits[k] = 1'b1;
    end
    case (gctl[1:0])
      2'd0: gb = 224;
      2'd1: gb = 226;
      2'd2: gb = 228;
      default: gb = 234;
    endcase
    if (gctl[7] && int'(a) >= gb && int'(a) < gb + 2) hits[6] = 1'b1;
    for (int k = 0; k < 7; k++)
      if (hits[k]) return 7'(1 << k);
    return '0;
  endfunction

  task automatic load_cfg();
    for (int k = 0; k < ND; k++) begin
      act_v[k*8 +: 8] = c_act[k];
      hi_v[k*8 +: 8]  = c_base[k][15:8];
      lo_v[k*8 +: 8]  = c_base[k][7:0];
    end
  endtask

  task automatic check(string tag, logic [15:0] a, logic [6:0] es, logic em);
    checks++;
    if (sel !== es || miss !== em) begin
      errors++;
      $display("FAIL %s addr=%h sel=%b miss=%b expected sel=%b miss=%b",
               tag, a, sel, miss, es, em);
    end
  endtask

  task automatic sweep(string tag, logic stb);
    for (int a = 0; a < 8192; a++) begin
      logic [6:0] es;
      @(negedge clk);
      addr = 16'(a);
      strobe = stb;
      #5;
      es = stb ? model_sel(16'(a)) : '0;
      check(tag, 16'(a), es, stb && es == '0);
    end
  endtask

  task automatic probe(string tag, logic [15:0] a, logic [6:0] es);
    @(negedge clk);
    addr = a;
    strobe = 1'b1;
    #5;
    check(tag, a, es, es == '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    addr = '0; strobe = 1'b0; irq_in = '0;
    glb = 8'h39; gctl = 8'h03;
    c_act  = '{8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0};
    c_base = '{16'h03F0, 16'h03F8, 16'h02F8, 16'h0378, 16'h0000, 16'h0000};
    load_cfg();

    // R8: idle state, nothing selected
    @(negedge clk); #5;
    check("R8 idle", addr, '0, 1'b0);

    // R3 R9: power-on style layout
    sweep("R3", 1'b1);
    probe("R3 floppy last byte", 16'h03F7, 7'b0000001);
    probe("R3 high bits compared", 16'h13F8, 7'b0000000);
    sweep("R8", 1'b0);

    // R7: overlapping windows, priority order, GPIO at 0xE4
    glb = 8'h79; gctl = 8'h82;
    c_act  = '{8'd1, 8'd2, 8'h80, 8'd1, 8'd1, 8'd1};
    c_base = '{16'h0300, 16'h0304, 16'h0300, 16'h0302, 16'h0301, 16'h0305};
    load_cfg();
    sweep("R7", 1'b1);
    probe("R7 floppy beats others", 16'h0302, 7'b0000001);
    probe("R6 gpio 0xE5", 16'h00E5, 7'b1000000);

    // R4: range edges, GPIO at 0xE0
    gctl = 8'h80;
    c_base = '{16'h0FF9, 16'h0FF8, 16'h00FF, 16'h0FFC, 16'h0FFF, 16'h0FFD};
    load_cfg();
    sweep("R4", 1'b1);
    probe("R4 legal edge uart", 16'h0FFF, 7'b0000010);
    probe("R4 low base dead", 16'h0100, 7'b0000000);

    // R1 R5: globals off, aux still live, gpio bit7 clear
    glb = 8'h86; gctl = 8'h7F;
    c_act  = '{8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1};
    c_base = '{16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h0600};
    load_cfg();
    sweep("R1", 1'b1);
    probe("R5 aux without global", 16'h0500, 7'b0010000);
    probe("R6 gpio off", 16'h00EA, 7'b0000000);

    // R2: activate bytes zero
    glb = 8'hFF; gctl = 8'h83;
    c_act = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
    load_cfg();
    sweep("R2", 1'b1);
    probe("R6 gpio default 0xEA", 16'h00EB, 7'b1000000);
    probe("R6 gpio 0xE9 outside", 16'h00E9, 7'b0000000);
    gctl = 8'h81;
    probe("R6 gpio 0xE2", 16'h00E2, 7'b1000000);

    // R10 R11: interrupt code mapping, settles same cycle
    for (int v = 0; v < 256; v++) begin
      logic [7:0] ei;
      @(negedge clk);
      irq_in = 8'(v);
      #5;
      ei = (v > 15) ? 8'hFF : 8'(v);
      checks++;
      if (irq_out !== ei) begin
        errors++;
        $display("FAIL R10 irq in=%0d out=%h expected=%h", v, irq_out, ei);
      end
    end
    $display("R11 all results sampled in the stimulus cycle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule